// File: doc/BRIEF.md
# Buffered Program Word Loader

The loader sits between the flash command decoder and the flash array. It gathers a short burst of 32-bit words into a local staging buffer and then writes them into the array as one operation. After the decoder pulses `start_i`, the loader owns the bus write path. The first write gives the word count. The data writes that follow fill the buffer at positions measured from a base address, and the base is taken from the first data write. The first write that the buffer cannot take ends the load. It is treated as a confirm command.

A confirm whose low byte is 0xD0 starts a commit. The loader first queries the block-lock logic with the base address. If the block is unlocked, it announces the commit with the base and the byte length, then streams the words to the array one per clock and pulses `done_o` after the last word. If the block is locked, or the terminating byte is anything other than 0xD0, the loader returns to idle and raises status flag bits for the status register to merge.

Top module: `wbuf_loader`

## Requirements
- R1: While reset is high and on the cycle after it, `active_o`, `arr_we_o`, `commit_o` and `done_o` are 0 and `err_o` is 0x00.
- R2: A `start_i` pulse outside a commit raises `active_o` and restarts the sequence from the count phase, even in the middle of an earlier count or load.
- R3: The expected word total is bits [15:0] of the first write after `start_i`, plus one, capped at 32. Bits [31:16] are ignored.
- R4: The first data write sets the base address, and its word lands at buffer slot 0. A later accepted write at byte address A lands at slot (A − base)/4.
- R5: A data write is refused if its address is below the base, if it lies 128 or more bytes above the base, or if the expected total has already been accepted. A refused write ends the load, and its data low byte is checked as a confirm code. Any data value, including 0xD0, is stored when the write is accepted.
- R6: A 0xD0 confirm on an unlocked block pulses `commit_o` with `commit_base_o` equal to the base and `commit_bytes_o` equal to 4 times the accepted word count. The loader then drives `arr_we_o` on consecutive cycles, one per accepted word, at base, base+4, base+8 and so on, in slot order.
- R7: A terminating byte other than 0xD0 pulses `err_o` = 0x10 and writes nothing to the array.
- R8: When `lock_i` is high for the base at confirm time, `err_o` pulses 0x12 and no array write or commit takes place.
- R9: `done_o` pulses together with the last array write. Bus writes and `start_i` are ignored from the confirm until `active_o` has dropped, which happens on the cycle after `done_o`. Bus writes while idle change nothing.
- R10: Every slot is zero after `start_i`. A slot inside the committed range that no accepted write filled is written to the array as 0x00000000, even if an earlier burst left data in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Setup pulse from the command decoder |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | AW | Bus byte address (word aligned) |
| wr_data_i | input | 32 | Bus write data |
| lock_addr_o | output | AW | Base address presented to the block-lock logic |
| lock_i | input | 1 | Block holding `lock_addr_o` is locked |
| active_o | output | 1 | Loader owns the write path (count, load or commit) |
| commit_o | output | 1 | One-cycle commit announcement |
| commit_base_o | output | AW | Commit start byte address |
| commit_bytes_o | output | 8 | Commit length in bytes |
| arr_we_o | output | 1 | Array word write strobe |
| arr_addr_o | output | AW | Array write byte address |
| arr_data_o | output | 32 | Array write data |
| done_o | output | 1 | Pulses with the last array write |
| err_o | output | 8 | Status bits to set, pulsed for one cycle (0x10 or 0x12) |

## Verification
The bound checker checks these rules on every cycle:
- the state right after reset;
- that only the two legal error codes appear;
- that an error pulse never coincides with a commit or an array write;
- that the commit length is a legal multiple of four;
- that array addresses step by four within a stream;
- that the number of streamed words equals the announced length when `done_o` pulses.

Some behaviours can only be shown by the bench scenarios, because they depend on what was written earlier:
- the data placed in each slot and the zero fill of holes;
- that the count field is capped and its upper bits are ignored;
- which write ends the load;
- that writes and restarts issued during a commit are ignored.

// File: rtl/wbl_pkg.sv
package wbl_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_COUNT, PH_LOAD, PH_DRAIN} phase_t;
  localparam logic [7:0] CONFIRM_CODE = 8'hD0;
  localparam logic [7:0] ERR_SEQ      = 8'h10;
  localparam logic [7:0] ERR_LOCKED   = 8'h12;
endpackage

// File: rtl/wbl_stage_ram.sv
module wbl_stage_ram #(
  parameter int DW    = 32,
  parameter int WORDS = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0]    mem [WORDS];
  logic [WORDS-1:0] filled;

  // Plain array: no reset, one write port and one registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[rd_idx];
  end

  // Per-slot fill flags give the zero-cleared view without wiping the array.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      filled <= '0;
      rvalid <= 1'b0;
    end else begin
      if (we) filled[waddr] <= 1'b1;
      rvalid <= filled[rd_idx];
    end
  end
endmodule

// File: rtl/wbl_window.sv
module wbl_window #(
  parameter int WAW   = 18,
  parameter int WORDS = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int CW   = IW + 1
) (
  input  logic [WAW-1:0] addr_w,
  input  logic [WAW-1:0] base_w,
  input  logic           base_vld,
  input  logic [CW-1:0]  acc_cnt,
  input  logic [CW-1:0]  exp_len,
  output logic           accept,
  output logic [IW-1:0]  slot
);
  logic [WAW-1:0] diff;
  logic           in_win;

  always_comb begin
    diff   = addr_w - base_w;
    in_win = (addr_w >= base_w) && (diff < WAW'(WORDS));
    accept = !base_vld || (in_win && (acc_cnt < exp_len));
    slot   = base_vld ? diff[IW-1:0] : '0;
  end
endmodule

// File: rtl/wbl_drain.sv
module wbl_drain #(
  parameter int AW    = 20,
  parameter int DW    = 32,
  parameter int WORDS = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int CW   = IW + 1,
  localparam int WAW  = AW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [CW-1:0]  len,
  input  logic [WAW-1:0] base_w,
  output logic [IW-1:0]  rd_idx,
  input  logic [DW-1:0]  rdata,
  input  logic           rvalid,
  output logic           arr_we,
  output logic [AW-1:0]  arr_addr,
  output logic [DW-1:0]  arr_data,
  output logic           done
);
  logic           run;
  logic [IW-1:0]  idx, last_idx, s1_idx;
  logic [WAW-1:0] base_q;
  logic           s1_v, s1_last;

  assign rd_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      base_q   <= '0;
    end else if (go) begin
      run      <= 1'b1;
      idx      <= '0;
      last_idx <= IW'(len - CW'(1));
      base_q   <= base_w;
    end else if (run) begin
      if (idx == last_idx) run <= 1'b0;
      else                 idx <= idx + IW'(1);
    end
  end

  // Stage 1 lines up with the RAM read; stage 2 drives the array port.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_last  <= 1'b0;
      s1_idx   <= '0;
      arr_we   <= 1'b0;
      arr_addr <= '0;
      arr_data <= '0;
      done     <= 1'b0;
    end else begin
      s1_v     <= run;
      s1_last  <= run && (idx == last_idx);
      s1_idx   <= idx;
      arr_we   <= s1_v;
      arr_addr <= {base_q + WAW'(s1_idx), 2'b00};
      arr_data <= (s1_v && rvalid) ? rdata : '0;
      done     <= s1_v && s1_last;
    end
  end
endmodule

// File: rtl/wbuf_loader.sv
module wbuf_loader #(
  parameter int AW    = 20,
  parameter int WORDS = 32,
  localparam int DW   = 32,
  localparam int IW   = $clog2(WORDS),
  localparam int CW   = IW + 1,
  localparam int BW   = CW + 2,
  localparam int WAW  = AW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [AW-1:0] lock_addr_o,
  input  logic          lock_i,
  output logic          active_o,
  output logic          commit_o,
  output logic [AW-1:0] commit_base_o,
  output logic [BW-1:0] commit_bytes_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [DW-1:0] arr_data_o,
  output logic          done_o,
  output logic [7:0]    err_o
);
  import wbl_pkg::*;

  phase_t         ph;
  logic [CW-1:0]  exp_len, acc_cnt;
  logic [WAW-1:0] base_w;
  logic           base_vld;
  logic           accept;
  logic [IW-1:0]  slot, rd_idx;
  logic [DW-1:0]  rdata;
  logic           rvalid;
  logic           restart, load_wr, ram_we, confirm_ok, go;
  logic [CW-1:0]  req_len;
  logic           unused_lo;

  assign unused_lo = ^wr_addr_i[1:0];

  always_comb begin
    logic [16:0] n;
    n       = {1'b0, wr_data_i[15:0]} + 17'd1;
    req_len = (n > 17'(WORDS)) ? CW'(WORDS) : n[CW-1:0];
  end

  assign restart    = start_i && (ph != PH_DRAIN);
  assign load_wr    = (ph == PH_LOAD) && wr_en_i && !start_i;
  assign ram_we     = load_wr && accept;
  assign confirm_ok = wr_data_i[7:0] == CONFIRM_CODE;
  assign go         = load_wr && !accept && confirm_ok && !lock_i;

  assign lock_addr_o = {base_w, 2'b00};
  assign active_o    = ph != PH_IDLE;

  wbl_window #(.WAW(WAW), .WORDS(WORDS)) u_win (
    .addr_w(wr_addr_i[AW-1:2]), .base_w(base_w), .base_vld(base_vld),
    .acc_cnt(acc_cnt), .exp_len(exp_len), .accept(accept), .slot(slot)
  );

  wbl_stage_ram #(.DW(DW), .WORDS(WORDS)) u_ram (
    .clk(clk), .rst(rst), .clr(restart), .we(ram_we), .waddr(slot),
    .wdata(wr_data_i), .rd_idx(rd_idx), .rdata(rdata), .rvalid(rvalid)
  );

  wbl_drain #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_drain (
    .clk(clk), .rst(rst), .go(go), .len(acc_cnt), .base_w(base_w),
    .rd_idx(rd_idx), .rdata(rdata), .rvalid(rvalid), .arr_we(arr_we_o),
    .arr_addr(arr_addr_o), .arr_data(arr_data_o), .done(done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph             <= PH_IDLE;
      exp_len        <= '0;
      acc_cnt        <= '0;
      base_w         <= '0;
      base_vld       <= 1'b0;
      commit_o       <= 1'b0;
      commit_base_o  <= '0;
      commit_bytes_o <= '0;
      err_o          <= '0;
    end else begin
      commit_o <= 1'b0;
      err_o    <= '0;
      if (ph == PH_DRAIN) begin
        if (done_o) ph <= PH_IDLE;
      end else if (restart) begin
        ph       <= PH_COUNT;
        acc_cnt  <= '0;
        base_vld <= 1'b0;
      end else if (wr_en_i) begin
        unique case (ph)
          PH_COUNT: begin
            exp_len <= req_len;
            ph      <= PH_LOAD;
          end
          PH_LOAD: begin
            if (accept) begin
              acc_cnt <= acc_cnt + CW'(1);
              if (!base_vld) begin
                base_w   <= wr_addr_i[AW-1:2];
                base_vld <= 1'b1;
              end
            end else if (!confirm_ok) begin
              err_o <= ERR_SEQ;
              ph    <= PH_IDLE;
            end else if (lock_i) begin
              err_o <= ERR_LOCKED;
              ph    <= PH_IDLE;
            end else begin
              commit_o       <= 1'b1;
              commit_base_o  <= {base_w, 2'b00};
              commit_bytes_o <= {acc_cnt, 2'b00};
              ph             <= PH_DRAIN;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wbl_loader_chk.sv
module wbl_loader_chk #(
  parameter int AW    = 20,
  parameter int WORDS = 32,
  localparam int BW   = $clog2(WORDS) + 3
) (
  input logic          clk,
  input logic          rst,
  input logic          active_o,
  input logic          commit_o,
  input logic [BW-1:0] commit_bytes_o,
  input logic          arr_we_o,
  input logic [AW-1:0] arr_addr_o,
  input logic          done_o,
  input logic [7:0]    err_o
);
  logic [BW-1:0] want_q, seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q <= '0;
      seen_q <= '0;
    end else if (commit_o) begin
      want_q <= commit_bytes_o >> 2;
      seen_q <= '0;
    end else if (arr_we_o) begin
      seen_q <= seen_q + BW'(1);
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!active_o && !arr_we_o && !commit_o && !done_o && err_o == 8'h00)); // R1
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    (err_o != 8'h00) |-> (err_o == 8'h10 || err_o == 8'h12)); // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (err_o != 8'h00) |-> (!commit_o && !arr_we_o)); // R8
  AST_COMMIT_SIZE: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (commit_bytes_o != '0 && commit_bytes_o <= BW'(WORDS * 4)
                  && commit_bytes_o[1:0] == 2'b00)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o == $past(arr_addr_o) + AW'(4))); // R6
  AST_WORD_COUNT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (seen_q + BW'(1) == want_q)); // R6
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (rst)
    done_o |-> arr_we_o); // R9
  AST_WE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> active_o); // R9
endmodule

bind wbuf_loader wbl_loader_chk #(.AW(AW), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst(rst), .active_o(active_o), .commit_o(commit_o),
  .commit_bytes_o(commit_bytes_o), .arr_we_o(arr_we_o),
  .arr_addr_o(arr_addr_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/wbuf_loader_test.sv
module wbuf_loader_test;
  localparam int AW = 20;
  localparam int WORDS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [AW-1:0] lock_addr_o, commit_base_o, arr_addr_o;
  logic lock_i, active_o, commit_o, arr_we_o, done_o;
  logic [7:0] commit_bytes_o, err_o;
  logic [31:0] arr_data_o;
  logic lock_en = 1'b0;

  always #10 clk = ~clk;

  // Locked region for the bench: byte addresses 0x40000..0x4FFFF
  assign lock_i = lock_en && (lock_addr_o >= 20'h40000) && (lock_addr_o < 20'h50000);

  wbuf_loader #(.AW(AW), .WORDS(WORDS)) uut (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // capture of outputs
  int cap_n = 0, commit_n = 0, done_n = 0;
  logic [AW-1:0] cap_a [64];
  logic [31:0]   cap_d [64];
  logic [AW-1:0] cbase;
  logic [7:0]    cbytes, errv = 8'h00;

  always @(negedge clk) if (!rst) begin
    if (arr_we_o && cap_n < 64) begin cap_a[cap_n] = arr_addr_o; cap_d[cap_n] = arr_data_o; cap_n++; end
    if (commit_o) begin commit_n++; cbase = commit_base_o; cbytes = commit_bytes_o; end
    if (err_o != 8'h00) errv = err_o;
    if (done_o) done_n++;
  end

  // reference model
  int m_ph = 0, m_exp = 0, m_cnt = 0, m_base = 0;
  bit m_bv = 0;
  logic [31:0] m_buf [32];
  bit m_val [32];
  bit e_commit = 0;
  int e_words = 0, e_base = 0;
  logic [7:0] e_err = 8'h00;

  task automatic m_start();
    if (m_ph != 3) begin
      m_ph = 1; m_cnt = 0; m_bv = 0;
      for (int i = 0; i < 32; i++) m_val[i] = 0;
    end
  endtask

  task automatic m_write(input int a, input logic [31:0] d);
    if (m_ph == 1) begin
      int n;
      n = int'(d[15:0]) + 1;
      m_exp = (n > 32) ? 32 : n;
      m_ph = 2;
    end else if (m_ph == 2) begin
      bit acc;
      int off;
      if (!m_bv) begin acc = 1; off = 0; end
      else begin
        off = (a - m_base) / 4;
        acc = (a >= m_base) && ((a - m_base) < 128) && (m_cnt < m_exp);
      end
      if (acc) begin
        if (!m_bv) begin m_base = a; m_bv = 1; end
        m_buf[off] = d; m_val[off] = 1; m_cnt++;
      end else if (d[7:0] == 8'hD0) begin
        if (lock_en && m_base >= 32'h40000 && m_base < 32'h50000) begin e_err = 8'h12; m_ph = 0; end
        else begin e_commit = 1; e_words = m_cnt; e_base = m_base; m_ph = 3; end
      end else begin
        e_err = 8'h10; m_ph = 0;
      end
    end
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1; m_start();
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a[AW-1:0]; wr_data_i = d; m_write(a, d);
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    chk(commit_n == int'(e_commit), "R6", "commit pulses", commit_n, e_commit);
    if (e_commit) begin
      chk(cbase == e_base[AW-1:0], "R4", "commit base", cbase, e_base);
      chk(cbytes == 8'(e_words * 4), "R6", "commit bytes", cbytes, e_words * 4);
      chk(cap_n == e_words, "R6", "array writes", cap_n, e_words);
      for (int i = 0; i < e_words && i < cap_n; i++) begin
        chk(cap_a[i] == 20'(e_base + 4 * i), "R6", "array addr", cap_a[i], e_base + 4 * i);
        chk(cap_d[i] == (m_val[i] ? m_buf[i] : 32'h0), "R10", "array data", cap_d[i],
            m_val[i] ? m_buf[i] : 32'h0);
      end
      chk(done_n == 1, "R9", "done pulses", done_n, 1);
    end else begin
      chk(cap_n == 0, (e_err == 8'h12) ? "R8" : "R7", "no array writes", cap_n, 0);
    end
    chk(errv == e_err, (e_err == 8'h12) ? "R8" : "R7", "error bits", errv, e_err);
    chk(active_o == 1'b0, "R9", "released", active_o, 0);
    cap_n = 0; commit_n = 0; done_n = 0; errv = 8'h00;
    e_commit = 0; e_err = 8'h00; e_words = 0;
    if (m_ph == 3) m_ph = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, cw;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!active_o && !arr_we_o && !commit_o && !done_o && err_o == 0, "R1", "outputs in reset",
        {active_o, arr_we_o, commit_o, done_o, err_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!active_o && !arr_we_o && err_o == 0, "R1", "idle after reset", {active_o, arr_we_o, err_o}, 0);

    // R2 R3 R4 R6: plain four-word burst, refused by count reached
    do_start();
    chk(active_o == 1'b1, "R2", "active after start", active_o, 1);
    wr(0, 32'h0000_0003);
    for (int i = 0; i < 4; i++) wr(32'h1000 + 4 * i, 32'hA000_0000 + i);
    wr(32'h1000, 32'h0000_00D0);
    settle();

    // R10 R5: hole left in slot 1, confirm below base
    do_start(); wr(0, 32'h0000_0004);
    wr(32'h2008, 32'h1111_1111); wr(32'h2010, 32'h3333_3333);
    wr(32'h2004, 32'hFFFF_FFD0);
    settle();

    // R5: offset of 128 bytes refused, with D0 and with another code (R7)
    do_start(); wr(0, 32'h0000_0010);
    wr(32'h3000, 32'h5); wr(32'h3080, 32'h0000_12D0);
    settle();
    do_start(); wr(0, 32'h0000_0010);
    wr(32'h3000, 32'h5); wr(32'h3080, 32'h0000_0055);
    settle();

    // R3: upper count bits ignored, and both clamps to 32
    do_start(); wr(0, 32'hABCD_0001);
    wr(32'h6000, 32'h77); wr(32'h6004, 32'h88); wr(32'h6008, 32'hD0);
    settle();
    do_start(); wr(0, 32'h0000_FFFF);
    for (int i = 0; i < 32; i++) wr(32'h8000 + 4 * i, 32'hC000_0000 + i);
    wr(32'h8080, 32'hD0);
    settle();
    do_start(); wr(0, 32'h0000_0040);
    for (int i = 0; i < 32; i++) wr(32'h9000 + 4 * i, 32'h5A00_0000 + i);
    wr(32'h9000, 32'hD0);
    settle();

    // R8: locked base
    lock_en = 1'b1;
    do_start(); wr(0, 32'h0000_0002);
    wr(32'h40100, 32'h1); wr(32'h400FC, 32'hD0);
    settle();
    lock_en = 1'b0;

    // R2: restart during load discards the first burst
    do_start(); wr(0, 32'h3);
    wr(32'hA000, 32'hDEAD_0001); wr(32'hA004, 32'hDEAD_0002);
    do_start(); wr(0, 32'h0);
    wr(32'hB000, 32'hBEEF_0001); wr(32'hB000, 32'hD0);
    settle();

    // R4 R5: 0xD0 accepted as data while the window has room
    do_start(); wr(0, 32'h1);
    wr(32'h5000, 32'h0000_00D0); wr(32'h5004, 32'h0000_00D0); wr(32'h5008, 32'h0000_00D0);
    settle();

    // R9: writes and restart during the commit are ignored; idle writes too
    do_start(); wr(0, 32'h5);
    for (int i = 0; i < 6; i++) wr(32'hC000 + 4 * i, 32'h6600_0000 + i);
    wr(32'hBFFC, 32'hD0);
    wr(32'hC000, 32'h0000_00D0);
    do_start();
    wr(32'hC004, 32'h1234_5678);
    settle();
    wr(32'hD000, 32'h0000_00D0);
    settle();

    // random bursts
    for (int b = 0; b < 40; b++) begin
      int base, nw;
      base = int'($urandom_range(1, 16'hFFFF)) * 4;
      cw = $urandom; cw[15:0] = 16'($urandom_range(0, 40));
      nw = int'($urandom_range(1, 36));
      do_start();
      wr(0, cw);
      rv = $urandom; wr(base, rv);
      for (int k = 0; k < nw; k++) begin
        int off;
        off = int'($urandom_range(0, 37));
        rv = $urandom;
        wr(base + 4 * off, rv);
      end
      rv = $urandom;
      rv[7:0] = ($urandom_range(0, 9) == 0) ? 8'h3C : 8'hD0;
      wr(base - 4, rv);
      settle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule